// File: doc/BRIEF.md
# Hub Instruction Cache with Line Prefetch

This block sits in front of the instruction fetch stage of a processor core. The core shares a slow hub memory with other cores. The program counter is 16 bits wide and counts 32-bit words. Fetches below word 512 go to the core's own local register memory and never touch the cache. Every higher address up to 0xFFFF is served from a small cache of four lines of eight words each.

On a hit the instruction comes back in the same cycle. On a miss the block drops `fetchReady` and stalls the pipeline. It then asks the hub for the whole line, writes the eight returned words and marks the line valid, after which the stalled fetch completes.

The replacement victim is always the least-recently-used line. While the hub port is free and next-line prefetch is on, the block fetches the line that follows the one it last served. Three command strobes control the cache: one turns prefetch on, one turns it off, and one discards every cached line.

Top module: `hub_icache`

## Requirements
- R1: A fetch with `fetchAddr` below 0x200 completes in the same cycle. `fetchInstr` equals `localData`, `localAddr` carries `fetchAddr[8:0]`, and no hub request results from it.
- R2: A fetch at 0x200 or above that hits returns, in the same cycle, the word at offset `fetchAddr[2:0]` of the cached line whose tag equals `fetchAddr[15:3]`.
- R3: A fetch at 0x200 or above that misses holds `fetchReady` low. If no fill is in flight, `hubReq` rises on the next cycle with `hubAddr` equal to the fetch address with its low three bits cleared.
- R4: Once the eighth data beat of a demand fill has been taken, the stalled fetch completes on the following cycle with the correct word. Later fetches to that line hit with no stall.
- R5: During a fill, `hubReq` stays high and `hubAddr` stays constant until the eighth `hubValid` beat. Beats arrive in order, starting at offset 0.
- R6: A fill replaces the least-recently-used line. Both hits and fill starts count as uses.
- R7: After reset, prefetch is on. When the hub port is idle, the fetch in progress is not a miss, and the line after the last hit line is absent and at 0x200 or above, the block requests that next line. A prefetch never replaces the line last hit.
- R8: A pulse on `cmdPfOff` stops all requests except demand misses. A pulse on `cmdPfOn` restores prefetch.
- R9: A pulse on `cmdInval` makes every line invalid, so the next fetch to any hub address misses.
- R10: If `cmdInval` arrives while a fill is in flight, that fill still takes all eight beats, but its line stays invalid afterwards.
- R11: While reset is held and just after it is released, `hubReq` is low, no line is valid and prefetch is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | Fetch address is valid this cycle |
| fetchAddr | input | 16 | Word address of the instruction |
| fetchReady | output | 1 | Instruction is available; low while stalled |
| fetchInstr | output | 32 | Fetched instruction word |
| localAddr | output | 9 | Address into local register memory |
| localData | input | 32 | Word read combinationally from local memory |
| cmdInval | input | 1 | Invalidate all lines |
| cmdPfOn | input | 1 | Enable next-line prefetch |
| cmdPfOff | input | 1 | Disable next-line prefetch (wins over enable) |
| hubReq | output | 1 | Line fill request, high for the whole fill |
| hubAddr | output | 16 | Base word address of the requested line |
| hubValid | input | 1 | Data beat strobe from the hub |
| hubData | input | 32 | Data beat, in ascending word order |

## Verification
The hardest case to reach from the ports is an invalidate that lands inside a fill, after the request has gone out but before the eighth beat. The bench waits for `hubReq` to go high before pulsing `cmdInval`, because its hub model always waits at least one cycle before the first beat. It also drops `fetchValid` so that no new demand fill hides the effect. It then checks that the line misses again. Least-recently-used ordering is shown only through which later fetches stall. For that reason a directed sequence turns prefetch off, fills four lines, touches the oldest one and forces two evictions.

// File: rtl/hic_pkg.sv
package hic_pkg;
  localparam int unsigned PC_W       = 16;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned LINE_CNT   = 4;
  localparam int unsigned LINE_WORDS = 8;
  localparam int unsigned COG_WORDS  = 512;

  localparam int unsigned SLOT_W        = $clog2(LINE_CNT);
  localparam int unsigned OFF_W         = $clog2(LINE_WORDS);
  localparam int unsigned TAG_W         = PC_W - OFF_W;
  localparam int unsigned LOCAL_W       = $clog2(COG_WORDS);
  localparam int unsigned HUB_FIRST_TAG = COG_WORDS / LINE_WORDS;

  typedef logic [SLOT_W-1:0] slot_t;
  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [OFF_W-1:0]  off_t;
  typedef logic [LINE_CNT-1:0][SLOT_W-1:0] ageVec_t;

  typedef struct packed {
    logic  startFill;
    slot_t fillSlot;
    tag_t  fillTag;
    logic  beatWe;
    off_t  beat;
    logic  finishFill;
    logic  keepValid;
    logic  invalAll;
    logic  touch;
    slot_t touchSlot;
  } ctlStrobes_t;
endpackage

// File: rtl/hic_store.sv
module hic_store
  import hic_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  tag_t              lookTag,
  input  off_t              lookOff,
  input  tag_t              pfTag,
  input  logic [DATA_W-1:0] hubData,
  output logic              lookHit,
  output slot_t             lookSlot,
  output logic [DATA_W-1:0] lookWord,
  output logic              pfPresent,
  output slot_t             victimSlot,
  output logic              victimValid,
  output tag_t              victimTag
);
  logic [LINE_CNT-1:0] validQ;
  tag_t                tagQ  [LINE_CNT];
  logic [DATA_W-1:0]   dataQ [LINE_CNT][LINE_WORDS];
  ageVec_t             ageQ, ageN;
  logic [LINE_CNT-1:0] hitVec;

  // Make slot s the newest; every slot that was newer than s ages by one.
  function automatic ageVec_t promote(input ageVec_t a, input slot_t s);
    ageVec_t r;
    r = a;
    for (int i = 0; i < LINE_CNT; i++)
      if (a[i] < a[s]) r[i] = a[i] + slot_t'(1);
    r[s] = '0;
    return r;
  endfunction

  always_comb begin
    lookHit    = 1'b0;
    lookSlot   = '0;
    pfPresent  = 1'b0;
    victimSlot = '0;
    hitVec     = '0;
    for (int i = 0; i < LINE_CNT; i++) begin
      if (validQ[i] && tagQ[i] == lookTag) begin
        lookHit   = 1'b1;
        lookSlot  = slot_t'(i);
        hitVec[i] = 1'b1;
      end
      if (validQ[i] && tagQ[i] == pfTag) pfPresent = 1'b1;
      if (ageQ[i] == slot_t'(LINE_CNT - 1)) victimSlot = slot_t'(i);
    end
    victimValid = validQ[victimSlot];
    victimTag   = tagQ[victimSlot];
    lookWord    = dataQ[lookSlot][lookOff];
  end

  always_comb begin
    ageN = ageQ;
    if (ctl.touch)     ageN = promote(ageN, ctl.touchSlot);
    if (ctl.startFill) ageN = promote(ageN, ctl.fillSlot);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      for (int i = 0; i < LINE_CNT; i++) begin
        tagQ[i] <= '0;
        ageQ[i] <= slot_t'(i);
      end
    end else begin
      ageQ <= ageN;
      if (ctl.invalAll) validQ <= '0;
      if (ctl.startFill) begin
        tagQ[ctl.fillSlot]   <= ctl.fillTag;
        validQ[ctl.fillSlot] <= 1'b0;
      end
      if (ctl.finishFill && ctl.keepValid) validQ[ctl.fillSlot] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.beatWe) dataQ[ctl.fillSlot][ctl.beat] <= hubData;
  end

  // Ages must stay a permutation: each rank is held by exactly one slot.
  for (genvar v = 0; v < LINE_CNT; v++) begin : g_rank
    logic [LINE_CNT-1:0] holders;
    always_comb
      for (int i = 0; i < LINE_CNT; i++) holders[i] = (ageQ[i] == slot_t'(v));
    a_r6_age_rank_unique: assert property (@(posedge clk) disable iff (!rstN)
      $countones(holders) == 1);
  end

  a_r2_single_hit: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  a_r10_killed_fill_invalid: assert property (@(posedge clk) disable iff (!rstN)
    ctl.finishFill && !ctl.keepValid |=> !validQ[$past(ctl.fillSlot)]);
endmodule

// File: rtl/hic_ctrl.sv
module hic_ctrl
  import hic_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            fetchValid,
  input  logic [PC_W-1:0] fetchAddr,
  input  logic            cmdInval,
  input  logic            cmdPfOn,
  input  logic            cmdPfOff,
  input  logic            hubValid,
  input  logic            lookHit,
  input  slot_t           lookSlot,
  input  logic            pfPresent,
  input  slot_t           victimSlot,
  input  logic            victimValid,
  input  tag_t            victimTag,
  output ctlStrobes_t     ctl,
  output logic            isHub,
  output tag_t            pfTag,
  output logic            fetchReady,
  output logic            hubReq,
  output logic [PC_W-1:0] hubAddr
);
  logic  fillBusyQ, killQ, pfEnQ, lastValidQ;
  slot_t fillSlotQ;
  tag_t  fillTagQ, lastTagQ, fetchTag;
  off_t  beatQ;
  logic  hubHit, demandMiss, pfOk, canStart, startDemand, startPf, lastBeat;

  assign fetchTag = fetchAddr[PC_W-1:OFF_W];

  always_comb begin
    isHub       = fetchAddr >= PC_W'(COG_WORDS);
    hubHit      = fetchValid && isHub && lookHit;
    demandMiss  = fetchValid && isHub && !lookHit;
    fetchReady  = !demandMiss;
    pfTag       = lastTagQ + tag_t'(1);
    pfOk        = pfEnQ && lastValidQ && (pfTag >= tag_t'(HUB_FIRST_TAG)) && !pfPresent
                  && !(victimValid && victimTag == lastTagQ)
                  && !(hubHit && victimSlot == lookSlot);
    canStart    = !fillBusyQ && !cmdInval;
    startDemand = canStart && demandMiss;
    startPf     = canStart && !demandMiss && pfOk;
    lastBeat    = fillBusyQ && hubValid && beatQ == off_t'(LINE_WORDS - 1);

    ctl.startFill  = startDemand || startPf;
    ctl.fillSlot   = ctl.startFill ? victimSlot : fillSlotQ;
    ctl.fillTag    = startDemand ? fetchTag : pfTag;
    ctl.beatWe     = fillBusyQ && hubValid;
    ctl.beat       = beatQ;
    ctl.finishFill = lastBeat;
    ctl.keepValid  = !killQ && !cmdInval;
    ctl.invalAll   = cmdInval;
    ctl.touch      = hubHit;
    ctl.touchSlot  = lookSlot;

    hubReq  = fillBusyQ;
    hubAddr = {fillTagQ, {OFF_W{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillBusyQ  <= 1'b0;
      killQ      <= 1'b0;
      pfEnQ      <= 1'b1;
      lastValidQ <= 1'b0;
      lastTagQ   <= '0;
      fillSlotQ  <= '0;
      fillTagQ   <= '0;
      beatQ      <= '0;
    end else begin
      if (ctl.startFill) begin
        fillBusyQ <= 1'b1;
        fillSlotQ <= victimSlot;
        fillTagQ  <= ctl.fillTag;
        beatQ     <= '0;
        killQ     <= 1'b0;
      end else if (fillBusyQ) begin
        if (cmdInval) killQ <= 1'b1;
        if (hubValid) beatQ <= beatQ + off_t'(1);
        if (lastBeat) fillBusyQ <= 1'b0;
      end
      if (cmdPfOff)     pfEnQ <= 1'b0;
      else if (cmdPfOn) pfEnQ <= 1'b1;
      if (hubHit) begin
        lastTagQ   <= fetchTag;
        lastValidQ <= 1'b1;
      end
    end
  end

  a_r3_miss_requests: assert property (@(posedge clk) disable iff (!rstN)
    demandMiss && !fillBusyQ && !cmdInval |=> hubReq && hubAddr[OFF_W-1:0] == '0);

  a_r5_req_held: assert property (@(posedge clk) disable iff (!rstN)
    hubReq && !(hubValid && beatQ == off_t'(LINE_WORDS - 1)) |=> hubReq && $stable(hubAddr));

  a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !pfEnQ && !demandMiss && !fillBusyQ |=> !hubReq);
endmodule

// File: rtl/hub_icache.sv
module hub_icache
  import hic_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               fetchValid,
  input  logic [PC_W-1:0]    fetchAddr,
  output logic               fetchReady,
  output logic [DATA_W-1:0]  fetchInstr,
  output logic [LOCAL_W-1:0] localAddr,
  input  logic [DATA_W-1:0]  localData,
  input  logic               cmdInval,
  input  logic               cmdPfOn,
  input  logic               cmdPfOff,
  output logic               hubReq,
  output logic [PC_W-1:0]    hubAddr,
  input  logic               hubValid,
  input  logic [DATA_W-1:0]  hubData
);
  ctlStrobes_t       ctl;
  logic              isHub, lookHit, pfPresent, victimValid;
  slot_t             lookSlot, victimSlot;
  tag_t              pfTag, victimTag;
  logic [DATA_W-1:0] lookWord;

  hic_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .cmdInval(cmdInval), .cmdPfOn(cmdPfOn), .cmdPfOff(cmdPfOff), .hubValid(hubValid),
    .lookHit(lookHit), .lookSlot(lookSlot), .pfPresent(pfPresent),
    .victimSlot(victimSlot), .victimValid(victimValid), .victimTag(victimTag),
    .ctl(ctl), .isHub(isHub), .pfTag(pfTag), .fetchReady(fetchReady),
    .hubReq(hubReq), .hubAddr(hubAddr)
  );

  hic_store u_store (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .lookTag(fetchAddr[PC_W-1:OFF_W]), .lookOff(fetchAddr[OFF_W-1:0]),
    .pfTag(pfTag), .hubData(hubData),
    .lookHit(lookHit), .lookSlot(lookSlot), .lookWord(lookWord),
    .pfPresent(pfPresent), .victimSlot(victimSlot),
    .victimValid(victimValid), .victimTag(victimTag)
  );

  assign localAddr  = fetchAddr[LOCAL_W-1:0];
  assign fetchInstr = isHub ? lookWord : localData;

  a_r1_local_no_stall: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid && !isHub |-> fetchReady && fetchInstr == localData);
endmodule

// File: tb/sim_hub_icache.sv
`timescale 1ns/1ps
module sim_hub_icache;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fetchValid = 1'b0;
  logic [15:0] fetchAddr = '0;
  logic        fetchReady;
  logic [31:0] fetchInstr;
  logic [8:0]  localAddr;
  logic [31:0] localData;
  logic        cmdInval = 1'b0, cmdPfOn = 1'b0, cmdPfOff = 1'b0;
  logic        hubReq;
  logic [15:0] hubAddr;
  logic        hubValid = 1'b0;
  logic [31:0] hubData = '0;

  int checks = 0, errors = 0, cyc = 0;
  int fillCount = 0;
  logic [15:0] lastFill = '0;

  always #4 clk = ~clk;

  hub_icache u0 (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .fetchReady(fetchReady), .fetchInstr(fetchInstr), .localAddr(localAddr),
    .localData(localData), .cmdInval(cmdInval), .cmdPfOn(cmdPfOn), .cmdPfOff(cmdPfOff),
    .hubReq(hubReq), .hubAddr(hubAddr), .hubValid(hubValid), .hubData(hubData)
  );

  function automatic logic [31:0] hubWord(input logic [15:0] a);
    return {a ^ 16'h5A3C, a};
  endfunction

  function automatic logic [31:0] expWord(input logic [15:0] a);
    if (a < 16'h0200) return {16'hC0DE, 7'd0, a[8:0]};
    return hubWord(a);
  endfunction

  assign localData = {16'hC0DE, 7'd0, localAddr};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Hub model: latency 1..4 cycles, then eight beats in a row.
  int hubState = 0, hubWait = 0, hubBeat = 0;
  logic [15:0] hubBase = '0;
  always @(negedge clk) begin
    if (!rstN) begin
      hubState = 0; hubValid = 1'b0;
    end else begin
      case (hubState)
        0: begin
          hubValid = 1'b0;
          if (hubReq) begin
            hubBase = hubAddr; fillCount++; lastFill = hubAddr;
            hubWait = $urandom_range(0, 3); hubState = 1;
          end
        end
        1: begin
          if (hubWait == 0) begin
            hubState = 2; hubBeat = 0; hubValid = 1'b1; hubData = hubWord(hubBase);
          end else hubWait--;
        end
        default: begin
          if (hubBeat == 7) begin
            hubValid = 1'b0; hubState = 0;
          end else begin
            hubBeat++;
            hubData = hubWord(hubBase + 16'(hubBeat));
            chk(hubReq && hubAddr == hubBase, "R5 request held during fill", {15'd0, hubReq, hubAddr}, {16'd1, hubBase});
          end
        end
      endcase
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic fetchOne(input logic [15:0] a, input string req, output int waits);
    @(negedge clk);
    fetchValid = 1'b1; fetchAddr = a;
    #1;
    waits = 0;
    while (!fetchReady && waits < 300) begin
      @(negedge clk); #1; waits++;
    end
    if (waits >= 300) chk(1'b0, req, 32'(waits), 32'd0);
    else chk(fetchInstr == expWord(a), req, fetchInstr, expWord(a));
    if (a < 16'h0200) chk(localAddr == a[8:0], "R1 local address", {23'd0, localAddr}, {23'd0, a[8:0]});
  endtask

  task automatic idle(input int n);
    @(negedge clk); fetchValid = 1'b0;
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pulseInval();
    @(negedge clk); cmdInval = 1'b1; @(negedge clk); cmdInval = 1'b0;
  endtask
  task automatic pulseOn();
    @(negedge clk); cmdPfOn = 1'b1; @(negedge clk); cmdPfOn = 1'b0;
  endtask
  task automatic pulseOff();
    @(negedge clk); cmdPfOff = 1'b1; @(negedge clk); cmdPfOff = 1'b0;
  endtask

  initial begin
    int w, base;
    logic [15:0] pc;
    void'($urandom(32'd20240607));
    repeat (4) @(negedge clk);
    #1;
    chk(hubReq == 1'b0, "R11 no request in reset", {31'd0, hubReq}, 32'd0);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk(hubReq == 1'b0 && fetchReady == 1'b1, "R11 idle after reset", {30'd0, hubReq, fetchReady}, 32'd1);

    // R1: local fetches
    base = fillCount;
    fetchOne(16'h0005, "R1 local word", w);
    chk(w == 0, "R1 no stall", 32'(w), 0);
    fetchOne(16'h01FF, "R1 local top word", w);
    chk(w == 0, "R1 no stall at 0x1FF", 32'(w), 0);
    idle(6);
    chk(fillCount == base, "R1 no hub traffic", 32'(fillCount), 32'(base));

    // R3/R4/R7/R11: first hub fetch misses, then the next line is prefetched
    fetchOne(16'h1005, "R3 miss data", w);
    chk(w > 0, "R11 cache empty after reset", 32'(w), 32'd1);
    chk(lastFill == 16'h1000, "R3 line base address", {16'd0, lastFill}, 32'h1000);
    fetchOne(16'h1002, "R4 same line hits", w);
    chk(w == 0, "R4 no stall after fill", 32'(w), 0);
    idle(40);
    chk(fillCount == base + 2, "R7 one prefetch", 32'(fillCount), 32'(base + 2));
    chk(lastFill == 16'h1008, "R7 prefetch is next line", {16'd0, lastFill}, 32'h1008);
    fetchOne(16'h100B, "R2 prefetched word", w);
    chk(w == 0, "R7 prefetched line hits", 32'(w), 0);
    idle(40);

    // R8/R9: prefetch off, invalidate
    pulseOff();
    pulseInval();
    base = fillCount;
    fetchOne(16'h100B, "R9 data after invalidate", w);
    chk(w > 0, "R9 invalidated line misses", 32'(w), 32'd1);
    idle(40);
    chk(fillCount == base + 1, "R8 no prefetch when off", 32'(fillCount), 32'(base + 1));
    pulseOn();
    idle(40);
    chk(fillCount == base + 2 && lastFill == 16'h1010, "R8 prefetch resumes", {16'(fillCount - base), lastFill}, {16'd2, 16'h1010});

    // R6: LRU replacement with prefetch off
    pulseOff();
    pulseInval();
    fetchOne(16'h2000, "R6 fill A", w);
    fetchOne(16'h2008, "R6 fill B", w);
    fetchOne(16'h2010, "R6 fill C", w);
    fetchOne(16'h2018, "R6 fill D", w);
    fetchOne(16'h2001, "R6 touch A", w);
    chk(w == 0, "R6 A resident", 32'(w), 0);
    fetchOne(16'h2020, "R6 fill E", w);
    chk(w > 0, "R6 E misses", 32'(w), 32'd1);
    fetchOne(16'h2009, "R6 B refill", w);
    chk(w > 0, "R6 B was evicted", 32'(w), 32'd1);
    fetchOne(16'h2003, "R6 A kept", w);
    chk(w == 0, "R6 A still resident", 32'(w), 0);
    fetchOne(16'h201F, "R6 D kept", w);
    chk(w == 0, "R6 D still resident", 32'(w), 0);
    fetchOne(16'h2024, "R6 E kept", w);
    chk(w == 0, "R6 E still resident", 32'(w), 0);
    fetchOne(16'h2012, "R6 C refill", w);
    chk(w > 0, "R6 C was evicted", 32'(w), 32'd1);

    // R10: invalidate during an in-flight fill
    idle(2);
    base = fillCount;
    @(negedge clk); fetchValid = 1'b1; fetchAddr = 16'h3000;
    @(negedge clk); #1;
    chk(hubReq == 1'b1, "R3 request raised after miss", {31'd0, hubReq}, 32'd1);
    fetchValid = 1'b0; cmdInval = 1'b1;
    @(negedge clk); cmdInval = 1'b0;
    #1;
    chk(hubReq == 1'b1, "R10 fill continues", {31'd0, hubReq}, 32'd1);
    idle(20);
    chk(hubReq == 1'b0 && fillCount == base + 1, "R10 fill completed", {15'd0, hubReq, 16'(fillCount - base)}, 32'd1);
    fetchOne(16'h3002, "R10 data after refill", w);
    chk(w > 0, "R10 killed line stays invalid", 32'(w), 32'd1);
    chk(fillCount == base + 2, "R10 line fetched again", 32'(fillCount), 32'(base + 2));

    // Random mix of local, sequential and jumping hub fetches with commands
    pulseOn();
    pc = 16'h4000;
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 3) pulseInval();
      else if (r < 5) pulseOff();
      else if (r < 7) pulseOn();
      r = $urandom_range(0, 99);
      if (r < 20) fetchOne(16'($urandom_range(0, 511)), "R1 random local", w);
      else begin
        if (r < 35) pc = 16'h4000 + 16'($urandom_range(0, 255));
        else pc = pc + 16'd1;
        fetchOne(pc, "R2 random hub", w);
      end
    end
    idle(30);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule